// File: doc/BRIEF.md
# Glitch-free four-way clock source switcher

This block picks the core clock at run time from four unrelated clock inputs: a slow watchdog oscillator, an internal RC oscillator, a crystal oscillator and an external clock pin. Software writes a source code and a clock-output enable bit through a small write port in the control clock domain. The block then moves the core clock from the old source to the new one. It never emits a shortened high or low phase. A status flag drops while the hand-over is in flight and rises once the new source is confirmed running.

The hand-over has three steps. Each source has its own lane, which brings the request into that source's domain through two flops. The lane opens or closes its gate only on that source's falling edge. A lane may open only once every other lane has closed. The gate states are brought back into the control domain through two more flops, and the status flag rises only when they show the new source alone.

A divided copy of the core clock can be sent to an output pin. The pin carries it only when software has enabled it, the core is not running from the crystal, and neither the real-time clock nor the watchdog timer uses the crystal.

Top module: `clksw_top`

## Requirements
- R1: The source code selects one of four clocks: 0 is the watchdog oscillator, 1 the RC oscillator, 2 the crystal and 3 the external pin. Once the status flag is 1 again after a write, `core_clk` runs at the frequency of the selected source.
- R2: A write accepted while `switch_done` is 1 makes `switch_done` read 0 in the control cycle that follows.
- R3: `switch_done` returns to 1 only after the new source's gate is confirmed in the control domain. After that, `cur_sel` holds the written code and `core_clk` runs from that source.
- R4: A write made while `switch_done` is 0 has no effect on the source selection or on the clock-output enable.
- R5: After reset, `cur_sel` reads 1 (RC oscillator), `switch_done` reads 1 and `core_clk` runs from the RC oscillator.
- R6: While the output is allowed and enabled, `clk_out` toggles at half the `core_clk` frequency.
- R7: `clk_out` stays 0 in any of these cases: the enable bit is 0, the selected code is 2 (crystal), `rtc_on_xtal` is 1, or `wdt_on_xtal` is 1.
- R8: At most one source gate is open at any time. No high or low phase of `core_clk` is shorter than the shortest half period among the four sources.
- R9: A write of the code that is already selected still drives `switch_done` to 0 and then back to 1. `core_clk` keeps running throughout, with no low phase longer than half a period of that source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ctl_clk | input | 1 | Control clock for the write port and the status flag |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_clk | input | 4 | Source clocks, indexed by source code |
| wr_en | input | 1 | Write strobe for the control register |
| wr_sel | input | 2 | Requested source code |
| wr_clkout_en | input | 1 | Requested clock-output enable |
| rtc_on_xtal | input | 1 | Real-time clock uses the crystal |
| wdt_on_xtal | input | 1 | Watchdog timer uses the crystal |
| core_clk | output | 1 | Selected core clock |
| clk_out | output | 1 | Core clock divided by two, gated |
| switch_done | output | 1 | 1 when no switch is in flight |
| cur_sel | output | 2 | Currently selected source code |

## Verification
A lane whose gate opens before the others have closed shows up directly at `core_clk` as a phase shorter than any source half period. A lane stuck closed keeps `switch_done` at 0 for good, which the bench treats as a timeout within a few thousand control cycles. A wrong selection register is visible in the count of `core_clk` edges within the first few microseconds after the flag rises, since the four source rates are well apart. A status flag that never drops, or a write that slips through while busy, shows on `switch_done` or `cur_sel` in the next control cycle.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
    localparam int unsigned NUM_SRC = 4;
    localparam int unsigned SEL_W   = $clog2(NUM_SRC);

    typedef enum logic [SEL_W-1:0] {
        SRC_WDOG = 2'd0,
        SRC_RC   = 2'd1,
        SRC_XTAL = 2'd2,
        SRC_EXT  = 2'd3
    } src_e;

    typedef struct packed {
        logic [SEL_W-1:0]   sel;
        logic               done;
        logic               oen;
        logic [NUM_SRC-1:0] ack1;
        logic [NUM_SRC-1:0] ack2;
    } ctl_s;
endpackage

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
    import clksw_pkg::*;
#(
    parameter int unsigned N   = NUM_SRC,
    parameter int unsigned SW  = SEL_W,
    parameter int unsigned RST = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic          wr_oen,
    input  logic [N-1:0]  lane_en,
    input  logic          rtc_on_xtal,
    input  logic          wdt_on_xtal,
    output logic [N-1:0]  req,
    output logic [SW-1:0] sel,
    output logic          done,
    output logic          out_allow
);
    ctl_s q, d;
    logic [N-1:0] want;

    always_comb begin
        want = '0;
        want[q.sel] = 1'b1;
    end

    always_comb begin
        d = q;
        d.ack1 = lane_en;
        d.ack2 = q.ack1;
        if (q.done) begin
            if (wr_en) begin
                d.sel  = wr_sel;
                d.oen  = wr_oen;
                d.done = 1'b0;
            end
        end else if (q.ack2 == want) begin
            d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sel  <= SW'(RST);
            q.done <= 1'b1;
            q.oen  <= 1'b0;
            q.ack1 <= N'(1) << RST;
            q.ack2 <= N'(1) << RST;
        end else begin
            q <= d;
        end
    end

    assign req       = want;
    assign sel       = q.sel;
    assign done      = q.done;
    assign out_allow = q.oen && (q.sel != SRC_XTAL) && !rtc_on_xtal && !wdt_on_xtal;

    assert_done_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && wr_en) |=> !q.done);
    assert_ignore_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.done && wr_en) |=> ($stable(q.sel) && $stable(q.oen)));
    assert_done_needs_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> $onehot(q.ack2));
endmodule

// File: rtl/clksw_lane.sv
module clksw_lane #(
    parameter bit ON_AT_RESET = 1'b0
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic req,
    input  logic others_on,
    output logic en
);
    logic s1_q, s2_q, en_q;
    logic s1_d;

    always_comb s1_d = req && !others_on;

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= ON_AT_RESET;
            s2_q <= ON_AT_RESET;
        end else begin
            s1_q <= s1_d;
            s2_q <= s1_q;
        end
    end

    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) en_q <= ON_AT_RESET;
        else        en_q <= s2_q;
    end

    assign en = en_q;
endmodule

// File: rtl/clksw_outdiv.sv
module clksw_outdiv (
    input  logic clk,
    input  logic rst_n,
    input  logic allow,
    output logic div_out
);
    logic div_q, div_d;

    always_comb div_d = !div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= 1'b0;
        else        div_q <= div_d;
    end

    assign div_out = div_q && allow;
endmodule

// File: rtl/clksw_top.sv
module clksw_top
    import clksw_pkg::*;
#(
    parameter int unsigned N       = NUM_SRC,
    parameter int unsigned SW      = SEL_W,
    parameter int unsigned RST_SEL = 1
) (
    input  logic          ctl_clk,
    input  logic          rst_n,
    input  logic [N-1:0]  src_clk,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic          wr_clkout_en,
    input  logic          rtc_on_xtal,
    input  logic          wdt_on_xtal,
    output logic          core_clk,
    output logic          clk_out,
    output logic          switch_done,
    output logic [SW-1:0] cur_sel
);
    logic [N-1:0] req, lane_en;
    logic         out_allow;

    clksw_ctrl #(.N(N), .SW(SW), .RST(RST_SEL)) u_ctrl (
        .clk(ctl_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_oen(wr_clkout_en), .lane_en(lane_en), .rtc_on_xtal(rtc_on_xtal),
        .wdt_on_xtal(wdt_on_xtal), .req(req), .sel(cur_sel),
        .done(switch_done), .out_allow(out_allow)
    );

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic [N-1:0] mask;
        assign mask = ~(N'(1) << i);
        clksw_lane #(.ON_AT_RESET(i == RST_SEL)) u_lane (
            .src_clk(src_clk[i]), .rst_n(rst_n), .req(req[i]),
            .others_on(|(lane_en & mask)), .en(lane_en[i])
        );
    end

    assign core_clk = |(src_clk & lane_en);

    clksw_outdiv u_div (
        .clk(core_clk), .rst_n(rst_n), .allow(out_allow), .div_out(clk_out)
    );

    assert_one_gate_R8: assert property (@(posedge ctl_clk) disable iff (!rst_n)
        $onehot0(lane_en));
    assert_clkout_block_R7: assert property (@(posedge ctl_clk) disable iff (!rst_n)
        (rtc_on_xtal || wdt_on_xtal || (cur_sel == SRC_XTAL)) |-> !clk_out);
endmodule

// File: tb/clksw_top_tb.sv
`timescale 1ns/1ps
module clksw_top_tb;
    logic ctl_clk = 0, rst_n = 0;
    logic [3:0] src_clk = '0;
    logic wr_en = 0, wr_clkout_en = 0, rtc_on_xtal = 0, wdt_on_xtal = 0;
    logic [1:0] wr_sel = 0;
    logic core_clk, clk_out, switch_done;
    logic [1:0] cur_sel;
    int checks = 0, fails = 0;
    bit finished = 0;
    localparam real HALF [4] = '{37.0, 7.0, 11.0, 15.0};
    localparam real WIN = 2960.0;

    clksw_top u_dut (.*);

    always #5 ctl_clk = ~ctl_clk;
    always #(HALF[0]) src_clk[0] = ~src_clk[0];
    always #(HALF[1]) src_clk[1] = ~src_clk[1];
    always #(HALF[2]) src_clk[2] = ~src_clk[2];
    always #(HALF[3]) src_clk[3] = ~src_clk[3];

    // edge counters and phase monitor
    int core_edges = 0, out_edges = 0, glitches = 0;
    real last_edge = 0.0, max_low = 0.0;
    bit gap_win = 0;
    always @(posedge clk_out) out_edges++;
    always @(core_clk) begin
        real w;
        w = $realtime - last_edge;
        if (rst_n && last_edge > 0.0 && w < 6.95) glitches++;
        if (core_clk) begin
            core_edges++;
            if (gap_win && w > max_low) max_low = w;
        end
        last_edge = $realtime;
    end

    function automatic int exp_edges(real period);
        return $rtoi(WIN / period);
    endfunction
    function automatic bit exp_out_on(bit oen, logic [1:0] s, bit rtc, bit wdt);
        return oen && s != 2'd2 && !rtc && !wdt;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write(logic [1:0] s, bit oen);
        @(negedge ctl_clk);
        wr_en = 1; wr_sel = s; wr_clkout_en = oen;
        @(negedge ctl_clk);
        wr_en = 0;
    endtask

    task automatic wait_done(string req);
        int n = 0;
        while (!switch_done && n < 4000) begin @(negedge ctl_clk); n++; end
        check(switch_done, req, switch_done, 1);
    endtask

    task automatic count_core(logic [1:0] s, string req);
        int c0, got, e;
        c0 = core_edges; #(WIN); got = core_edges - c0;
        e = exp_edges(2.0 * HALF[s]);
        check(got >= e - 1 && got <= e + 1, req, got, e);
    endtask

    task automatic count_out(bit on, logic [1:0] s, string req);
        int c0, got, e;
        c0 = out_edges; #(WIN); got = out_edges - c0;
        e = on ? exp_edges(4.0 * HALF[s]) : 0;
        check(on ? (got >= e - 1 && got <= e + 1) : got == 0, req, got, e);
    endtask

    task automatic do_switch(logic [1:0] s, bit oen);
        write(s, oen);
        check(switch_done == 0, "R2", switch_done, 0);
        wait_done("R3");
        check(cur_sel == s, "R3", cur_sel, s);
        count_core(s, "R1");
    endtask

    initial begin
        #(150000 * 10);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [1:0] s;
        bit oen, rtc, wdt;
        void'($urandom(32'd4711));
        #33 rst_n = 1;
        @(negedge ctl_clk);
        // R5 reset state
        check(switch_done == 1, "R5", switch_done, 1);
        check(cur_sel == 2'd1, "R5", cur_sel, 1);
        count_core(2'd1, "R5");
        count_out(0, 2'd1, "R7");
        // directed: every source once
        do_switch(2'd0, 0);
        do_switch(2'd2, 0);
        do_switch(2'd3, 0);
        do_switch(2'd1, 1);
        count_out(1, 2'd1, "R6");
        // R4: write while busy is ignored
        write(2'd0, 1);
        write(2'd3, 0);
        wait_done("R4");
        check(cur_sel == 2'd0, "R4", cur_sel, 0);
        count_out(1, 2'd0, "R4");
        // R9: same-source request
        do_switch(2'd3, 1);
        #200;
        max_low = 0.0; gap_win = 1;
        write(2'd3, 1);
        check(switch_done == 0, "R9", switch_done, 0);
        wait_done("R9");
        #100; gap_win = 0;
        check(max_low <= HALF[3] + 0.05, "R9", $rtoi(max_low), $rtoi(HALF[3]));
        // R7 blocking conditions
        rtc_on_xtal = 1; count_out(0, 2'd3, "R7");
        rtc_on_xtal = 0; wdt_on_xtal = 1; count_out(0, 2'd3, "R7");
        wdt_on_xtal = 0; count_out(1, 2'd3, "R6");
        do_switch(2'd2, 1);
        count_out(0, 2'd2, "R7");
        // random mix
        for (int i = 0; i < 14; i++) begin
            s = 2'($urandom_range(3));
            oen = 1'($urandom_range(1));
            rtc = ($urandom_range(3) == 0);
            wdt = ($urandom_range(3) == 0);
            rtc_on_xtal = rtc; wdt_on_xtal = wdt;
            do_switch(s, oen);
            count_out(exp_out_on(oen, s, rtc, wdt), s, "R6");
        end
        check(glitches == 0, "R8", glitches, 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule